// File: doc/BRIEF.md
# Page Residency Controller for a Two-Tier Memory

This block decides, for every read request, whether the data should come from a small fast memory or from a large slow backing memory. Residency is tracked in whole 64 KiB pages. The top address bits select a page. That page number is looked up in a small fully associative table. When the page is resident, the request is sent to the fast tier. When it is not, the request is sent to the slow tier straight away, so the client never waits. The page is also queued to be copied into the fast tier.

Queued pages become migration commands. Each command names the page, the table slot it will occupy and, if the slot was in use, the page being displaced. Each slot keeps a small saturating use counter, and the victim is the slot used least often. A frame pulse halves all counters so that old use fades. The same pulse reopens a per-frame allowance on how many migrations may start. The data movers report completion with an acknowledgement carrying the page number. Only that acknowledgement makes the page resident.

Top module: `page_tier_ctrl`

## Requirements
- R1: The page number of a request is `req_addr[ADDR_W-1:PAGE_SHIFT]` (default `PAGE_SHIFT`=16, that is 64 KiB pages). Any address inside a resident page is routed to the fast tier.
- R2: `req_ready` is always high. Every accepted request produces `route_valid` for exactly one cycle, in the cycle after acceptance. In that cycle `route_addr` equals the accepted address and `route_fast` gives the tier (1 = fast, 0 = slow).
- R3: A request for a page that is not resident is routed with `route_fast`=0 at the same latency as a hit. A migration command (`mig_page`, `mig_slot`) for that page is then issued.
- R4: A page is not resident from the cycle its command is issued until an acknowledgement with `ack_tag` equal to that page arrives. An acknowledgement whose tag matches no in-flight page changes nothing.
- R5: A miss on a page that is already waiting in the candidate queue, or already in flight, does not produce a second migration command.
- R6: At most `BUDGET` migration commands are started per frame. A `frame_start` pulse opens a new allowance, and a command may start in the same cycle as that pulse. Candidates left over wait in the queue.
- R7: The victim slot is chosen in this order:
  - the lowest-index slot that is neither resident nor in flight;
  - otherwise, the resident slot with the smallest use counter, lowest index on a tie.

  In-flight slots are never chosen. If every slot is in flight, no command starts. When a resident page is displaced, `mig_evict`=1 and `mig_old_page` names it.
- R8: Each hit adds 1 to the slot's use counter, saturating at its maximum. A newly installed slot starts at 1.
- R9: `frame_start` halves every use counter. A hit in the same cycle is added after the halving.
- R10: A miss that finds the candidate queue full (`FIFO_DEPTH` entries) is dropped and never migrated. The request itself is still routed to the slow tier.
- R11: A migration command stays on its outputs, unchanged, until `mig_ready` is seen. Commands leave in the order their pages were queued. After a handshake, at least one idle cycle passes before the next command.
- R12: After reset, `route_valid` and `mig_valid` are low, no page is resident, and `req_ready` and `ack_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_addr | input | ADDR_W | Request byte address |
| route_valid | output | 1 | Routing decision valid |
| route_fast | output | 1 | 1 = fast tier, 0 = slow tier |
| route_addr | output | ADDR_W | Address of the routed request |
| frame_start | input | 1 | One-cycle frame boundary pulse |
| mig_valid | output | 1 | Migration command present |
| mig_ready | input | 1 | Mover takes the command |
| mig_page | output | ADDR_W-PAGE_SHIFT | Page to copy into the fast tier |
| mig_slot | output | $clog2(ENTRIES) | Table slot that receives it |
| mig_evict | output | 1 | Slot held a resident page that is displaced |
| mig_old_page | output | ADDR_W-PAGE_SHIFT | Displaced page (when `mig_evict`) |
| ack_valid | input | 1 | Migration completed |
| ack_ready | output | 1 | Acknowledgement accepted (always high) |
| ack_tag | input | ADDR_W-PAGE_SHIFT | Page whose migration completed |

## Verification
Counter aging on `frame_start` and the hit increment can act on the same slot in the same cycle. The bench provokes this by sending a hit to slot 0 in the very cycle of a frame pulse. The counters are arranged beforehand so that the next victim differs depending on whether the increment is applied after the halving, lost, or applied to the unhalved value. The result is judged only at the ports, from the slot and the displaced page named in the next migration command. The frame pulse also coincides with the start of a held-back command, which checks that such a command is charged to the new frame's allowance.

// File: rtl/ptc_pkg.sv
// Package: shared definitions for the page residency controller.
// Assumes: nothing beyond standard SystemVerilog.
package ptc_pkg;
    // Routing decision encoding on route_fast
    typedef enum logic {
        TIER_SLOW = 1'b0,
        TIER_FAST = 1'b1
    } tier_e;

    // Default page size: 64 KiB pages, so the page number starts at bit 16
    localparam int unsigned PAGE_SHIFT_DEFAULT = 16;
endpackage

// File: rtl/ptc_fifo.sv
// ptc_fifo: candidate queue of page numbers waiting for migration.
// Adds a parallel probe that reports whether a page is already queued.
// Assumes: the caller never pushes when full nor pops when empty.
module ptc_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full,
    input  logic [W-1:0] probe,
    output logic         probe_hit
);
    logic [W-1:0]     mem [DEPTH];
    logic [DEPTH-1:0] occ;
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage, occupancy flags, pointers and fill count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            occ   <= '0;
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                mem[wr_q] <= push_data;
                occ[wr_q] <= 1'b1;
                wr_q      <= step(wr_q);
            end
            if (pop) begin
                occ[rd_q] <= 1'b0;
                rd_q      <= step(rd_q);
            end
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // Membership probe over all occupied entries
    always_comb begin
        probe_hit = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            if (occ[i] && mem[i] == probe) probe_hit = 1'b1;
    end

    assign head  = mem[rd_q];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/ptc_table.sv
// ptc_table: fully associative residency table.
// Each slot holds a resident flag, an in-flight flag, a page tag and a
// saturating use counter. Provides a lookup, counter aging, allocation,
// completion handling and least-used victim selection.
// Assumes: alloc targets only a slot that is not in flight; ack_en acts
// only on in-flight slots, so the two never touch the same slot.
module ptc_table #(
    parameter int ENTRIES = 32,
    parameter int TAG_W   = 16,
    parameter int CNT_W   = 4,
    localparam int SLOT_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_en,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic              lk_busy,
    input  logic              age_en,
    input  logic              alloc_en,
    input  logic [SLOT_W-1:0] alloc_slot,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic              ack_en,
    input  logic [TAG_W-1:0]  ack_tag,
    output logic              vic_ok,
    output logic [SLOT_W-1:0] vic_slot,
    output logic              vic_evict,
    output logic [TAG_W-1:0]  vic_tag
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [ENTRIES-1:0] vld_q, busy_q, hit_vec, busy_vec;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [CNT_W-1:0]   cnt_q  [ENTRIES];
    logic [CNT_W-1:0]   cnt_nx [ENTRIES];

    // Tag match per slot, and next counter value (halve first, then add a hit)
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            logic [CNT_W-1:0] aged;
            hit_vec[i]  = vld_q[i] && (tag_q[i] == lk_tag);
            busy_vec[i] = busy_q[i] && (tag_q[i] == lk_tag);
            aged        = age_en ? (cnt_q[i] >> 1) : cnt_q[i];
            cnt_nx[i]   = (lk_en && hit_vec[i] && aged != CNT_MAX) ? aged + 1'b1 : aged;
        end
    end

    assign lk_hit  = |hit_vec;
    assign lk_busy = |busy_vec;

    // Victim: first empty slot, else the least used resident slot
    always_comb begin
        logic             free_found;
        logic [CNT_W-1:0] best;
        free_found = 1'b0;
        best       = CNT_MAX;
        vic_ok     = 1'b0;
        vic_evict  = 1'b0;
        vic_slot   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!vld_q[i] && !busy_q[i] && !free_found) begin
                free_found = 1'b1;
                vic_slot   = SLOT_W'(i);
            end
        end
        if (free_found) begin
            vic_ok = 1'b1;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (vld_q[i] && !busy_q[i] && (!vic_ok || cnt_q[i] < best)) begin
                    vic_ok    = 1'b1;
                    vic_evict = 1'b1;
                    best      = cnt_q[i];
                    vic_slot  = SLOT_W'(i);
                end
            end
        end
        vic_tag = tag_q[vic_slot];
    end

    // Slot state: allocation, completion and counter update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            busy_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i] <= '0;
                cnt_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (alloc_en && alloc_slot == SLOT_W'(i)) begin
                    vld_q[i]  <= 1'b0;
                    busy_q[i] <= 1'b1;
                    tag_q[i]  <= alloc_tag;
                    cnt_q[i]  <= CNT_W'(1);
                end else begin
                    if (ack_en && busy_q[i] && tag_q[i] == ack_tag) begin
                        vld_q[i]  <= 1'b1;
                        busy_q[i] <= 1'b0;
                    end
                    cnt_q[i] <= cnt_nx[i];
                end
            end
        end
    end
endmodule

// File: rtl/page_tier_ctrl.sv
// page_tier_ctrl: routes reads to the fast or slow tier by page residency.
// It queues misses as migration candidates and issues at most BUDGET
// migration commands per frame, each into the least used slot.
// Assumes: frame_start is a one-cycle pulse; ENTRIES >= 2; the mover
// acknowledges each command once, with the page number it carried.
module page_tier_ctrl #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = ptc_pkg::PAGE_SHIFT_DEFAULT,
    parameter int ENTRIES    = 32,
    parameter int CNT_W      = 4,
    parameter int FIFO_DEPTH = 8,
    parameter int BUDGET     = 16,
    localparam int TAG_W     = ADDR_W - PAGE_SHIFT,
    localparam int SLOT_W    = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              route_valid,
    output logic              route_fast,
    output logic [ADDR_W-1:0] route_addr,
    input  logic              frame_start,
    output logic              mig_valid,
    input  logic              mig_ready,
    output logic [TAG_W-1:0]  mig_page,
    output logic [SLOT_W-1:0] mig_slot,
    output logic              mig_evict,
    output logic [TAG_W-1:0]  mig_old_page,
    input  logic              ack_valid,
    output logic              ack_ready,
    input  logic [TAG_W-1:0]  ack_tag
);
    import ptc_pkg::*;

    localparam int BUD_W = $clog2(BUDGET + 1);

    logic              acc, lk_hit, lk_busy;
    logic [TAG_W-1:0]  req_tag, q_head;
    logic              q_empty, q_full, q_has, push, load;
    logic              vic_ok, vic_evict;
    logic [SLOT_W-1:0] vic_slot;
    logic [TAG_W-1:0]  vic_tag;
    logic [BUD_W-1:0]  used_q;
    logic              budget_ok;

    assign req_ready = 1'b1;
    assign ack_ready = 1'b1;
    assign acc       = req_valid && req_ready;
    assign req_tag   = req_addr[ADDR_W-1:PAGE_SHIFT];

    // Queue a miss only if the page is not pending anywhere and room exists
    assign push      = acc && !lk_hit && !lk_busy && !q_has && !q_full;
    // A fresh frame reopens the allowance in the pulse cycle itself
    assign budget_ok = frame_start || (used_q < BUD_W'(BUDGET));
    assign load      = !mig_valid && !q_empty && vic_ok && budget_ok;

    ptc_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .lk_en(acc), .lk_tag(req_tag), .lk_hit(lk_hit), .lk_busy(lk_busy),
        .age_en(frame_start),
        .alloc_en(load), .alloc_slot(vic_slot), .alloc_tag(q_head),
        .ack_en(ack_valid), .ack_tag(ack_tag),
        .vic_ok(vic_ok), .vic_slot(vic_slot), .vic_evict(vic_evict), .vic_tag(vic_tag)
    );

    ptc_fifo #(.DEPTH(FIFO_DEPTH), .W(TAG_W)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_data(req_tag), .pop(load), .head(q_head),
        .empty(q_empty), .full(q_full), .probe(req_tag), .probe_hit(q_has)
    );

    // Routing decision register: one cycle after acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_valid <= 1'b0;
            route_fast  <= TIER_SLOW;
            route_addr  <= '0;
        end else begin
            route_valid <= acc;
            route_fast  <= lk_hit ? TIER_FAST : TIER_SLOW;
            route_addr  <= req_addr;
        end
    end

    // Migration command register: loaded when empty, held until taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mig_valid    <= 1'b0;
            mig_page     <= '0;
            mig_slot     <= '0;
            mig_evict    <= 1'b0;
            mig_old_page <= '0;
        end else if (load) begin
            mig_valid    <= 1'b1;
            mig_page     <= q_head;
            mig_slot     <= vic_slot;
            mig_evict    <= vic_evict;
            mig_old_page <= vic_tag;
        end else if (mig_valid && mig_ready) begin
            mig_valid <= 1'b0;
        end
    end

    // Per-frame count of started migrations
    always_ff @(posedge clk) begin
        if (!rst_n) used_q <= '0;
        else        used_q <= (frame_start ? '0 : used_q) + BUD_W'(load);
    end
endmodule

// File: rtl/ptc_chk.sv
// ptc_chk: protocol and policy checks for page_tier_ctrl, bound below.
// Assumes: connected by name to the ports of page_tier_ctrl.
module ptc_chk #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 16,
    parameter int ENTRIES    = 32,
    parameter int BUDGET     = 16,
    localparam int TAG_W     = ADDR_W - PAGE_SHIFT,
    localparam int SLOT_W    = $clog2(ENTRIES),
    localparam int CW        = $clog2(BUDGET + 2)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              route_valid,
    input logic [ADDR_W-1:0] route_addr,
    input logic              frame_start,
    input logic              mig_valid,
    input logic              mig_ready,
    input logic [TAG_W-1:0]  mig_page,
    input logic [SLOT_W-1:0] mig_slot,
    input logic              mig_evict,
    input logic [TAG_W-1:0]  mig_old_page
);
    logic          fs_d, mv_d;
    logic [CW-1:0] starts;

    // Count command starts per frame, aligned one cycle behind the pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_d   <= 1'b0;
            mv_d   <= 1'b0;
            starts <= '0;
        end else begin
            fs_d <= frame_start;
            mv_d <= mig_valid;
            if (starts != {CW{1'b1}})
                starts <= (fs_d ? '0 : starts) + CW'(mig_valid && !mv_d);
        end
    end

    assert_route_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (route_valid && route_addr == $past(req_addr)));

    assert_route_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !route_valid);

    assert_cmd_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mig_valid && !mig_ready) |=> (mig_valid && $stable(mig_page)
            && $stable(mig_slot) && $stable(mig_evict) && $stable(mig_old_page)));

    assert_frame_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        starts <= CW'(BUDGET));

    assert_no_self_evict_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mig_valid |-> !(mig_evict && mig_old_page == mig_page));
endmodule

bind page_tier_ctrl ptc_chk #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .ENTRIES(ENTRIES), .BUDGET(BUDGET)
) u_chk (.*);

// File: tb/page_tier_ctrl_test.sv
// page_tier_ctrl_test: scoreboard bench. Driver tasks queue the expected
// routes and migration commands; a monitor compares them at negedges.
module page_tier_ctrl_test;
    localparam int AW = 32;
    localparam int TW = 16;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          route_valid, route_fast;
    logic [AW-1:0] route_addr;
    logic          frame_start = 1'b0;
    logic          mig_valid;
    logic          mig_ready = 1'b1;
    logic [TW-1:0] mig_page, mig_old_page;
    logic [SW-1:0] mig_slot;
    logic          mig_evict;
    logic          ack_valid = 1'b0;
    logic          ack_ready;
    logic [TW-1:0] ack_tag = '0;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [AW:0]   exp_r[$];
    string         exp_rq[$];
    logic [34:0]   exp_m[$];
    string         exp_mq[$];

    page_tier_ctrl #(.ADDR_W(AW), .PAGE_SHIFT(16), .ENTRIES(4), .CNT_W(3),
                     .FIFO_DEPTH(4), .BUDGET(3)) uut (.*);

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic req(input logic [AW-1:0] a, input bit fast, input string rq);
        exp_r.push_back({fast, a});
        exp_rq.push_back(rq);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic req_frame(input logic [AW-1:0] a, input bit fast, input string rq);
        frame_start = 1'b1;
        req(a, fast, rq);
        frame_start = 1'b0;
    endtask

    task automatic exp_mig(input logic [TW-1:0] p, input logic [SW-1:0] s,
                           input bit ev, input logic [TW-1:0] old, input string rq);
        exp_m.push_back({p, s, ev, old});
        exp_mq.push_back(rq);
    endtask

    task automatic ack(input logic [TW-1:0] p);
        ack_valid = 1'b1;
        ack_tag   = p;
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic pulse_frame();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    // Monitor: compare routes and taken migration commands with the queues
    always @(negedge clk) begin
        if (rst_n) begin
            if (route_valid) begin
                if (exp_r.size() == 0) begin
                    chk(1'b0, "R2", "unexpected route", 64'(route_addr), 64'(0));
                end else begin
                    logic [AW:0] e;
                    string       rq;
                    e  = exp_r.pop_front();
                    rq = exp_rq.pop_front();
                    chk({route_fast, route_addr} == e, rq, "route {fast,addr}",
                        64'({route_fast, route_addr}), 64'(e));
                end
            end
            if (mig_valid && mig_ready) begin
                if (exp_m.size() == 0) begin
                    chk(1'b0, "R5", "unexpected migration page", 64'(mig_page), 64'(0));
                end else begin
                    logic [34:0] e;
                    logic [34:0] a;
                    string       rq;
                    e  = exp_m.pop_front();
                    rq = exp_mq.pop_front();
                    a  = {mig_page, mig_slot, mig_evict, mig_evict ? mig_old_page : 16'h0};
                    if (!e[16]) e[15:0] = 16'h0;
                    chk(a == e, rq, "migration {page,slot,evict,old}", 64'(a), 64'(e));
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failure and still reports
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // ---------- Scenario 1: install, hits, budget, victims, aging ----------
        do_reset();
        idle(1);
        chk(route_valid == 1'b0, "R12", "route_valid after reset", 64'(route_valid), 64'(0));
        chk(mig_valid == 1'b0, "R12", "mig_valid after reset", 64'(mig_valid), 64'(0));
        chk(req_ready && ack_ready, "R12", "ready outputs", 64'({req_ready, ack_ready}), 64'(3));

        // R3: first miss goes slow and is migrated into empty slot 0 (R7)
        exp_mig(16'h0001, 2'd0, 1'b0, 16'h0, "R3");
        req(32'h0001_0100, 1'b0, "R3");
        idle(4);
        // R4: a foreign ack leaves page 1 in flight; R5: no second command
        ack(16'h00FF);
        req(32'h0001_0200, 1'b0, "R4");
        ack(16'h0001);
        idle(2);
        // R1: another offset in the same 64 KiB page hits
        req(32'h0001_FFFC, 1'b1, "R1");

        // R6: budget of 3 per frame; page 4 must wait for the next frame
        exp_mig(16'h0002, 2'd1, 1'b0, 16'h0, "R6");
        exp_mig(16'h0003, 2'd2, 1'b0, 16'h0, "R6");
        req(32'h0002_0000, 1'b0, "R3");
        req(32'h0003_0000, 1'b0, "R3");
        req(32'h0004_0000, 1'b0, "R6");
        req(32'h0004_0040, 1'b0, "R5");
        idle(10);
        chk(mig_valid == 1'b0, "R6", "command held back by budget", 64'(mig_valid), 64'(0));
        ack(16'h0002);
        ack(16'h0003);
        exp_mig(16'h0004, 2'd3, 1'b0, 16'h0, "R6");
        pulse_frame();
        idle(4);
        ack(16'h0004);
        idle(2);

        // R8: counts now p1=3 p2=2 p3=1 p4=1 -> tie on 1, lowest index (slot 2)
        req(32'h0001_0000, 1'b1, "R8");
        req(32'h0001_0004, 1'b1, "R8");
        req(32'h0002_0000, 1'b1, "R8");
        req(32'h0002_0004, 1'b1, "R8");
        req(32'h0003_0000, 1'b1, "R8");
        exp_mig(16'h0005, 2'd2, 1'b1, 16'h0003, "R7");
        req(32'h0005_0000, 1'b0, "R7");
        idle(4);
        ack(16'h0005);
        idle(2);

        // R9: p1=3 p2=3 p5=4 p4=4, then halve with a same-cycle hit on p1:
        // p1=1+1=2, p2=1, p5=2, p4=2 -> victim is slot 1 (page 2)
        req(32'h0002_0008, 1'b1, "R8");
        req(32'h0005_0000, 1'b1, "R8");
        req(32'h0005_0004, 1'b1, "R8");
        req(32'h0005_0008, 1'b1, "R8");
        req(32'h0004_0000, 1'b1, "R8");
        req(32'h0004_0004, 1'b1, "R8");
        req(32'h0004_0008, 1'b1, "R8");
        req_frame(32'h0001_0010, 1'b1, "R9");
        exp_mig(16'h0006, 2'd1, 1'b1, 16'h0002, "R9");
        req(32'h0006_0000, 1'b0, "R9");
        idle(6);
        chk(exp_m.size() == 0, "R3", "scenario 1 commands outstanding", 64'(exp_m.size()), 64'(0));

        // ---------- Scenario 2: held command, full queue, no free slot ----------
        mig_ready = 1'b0;
        do_reset();
        for (int i = 0; i < 6; i++) req({16'h0010 + 16'(i), 16'h0000}, 1'b0, "R10");
        idle(3);
        chk(mig_valid && mig_page == 16'h0010, "R11", "command held while not ready",
            64'({mig_valid, mig_page}), 64'({1'b1, 16'h0010}));
        exp_mig(16'h0010, 2'd0, 1'b0, 16'h0, "R11");
        exp_mig(16'h0011, 2'd1, 1'b0, 16'h0, "R11");
        exp_mig(16'h0012, 2'd2, 1'b0, 16'h0, "R6");
        @(posedge clk);
        #1 mig_ready = 1'b1;
        @(negedge clk);
        idle(10);
        chk(mig_valid == 1'b0, "R6", "budget stops fourth start", 64'(mig_valid), 64'(0));
        exp_mig(16'h0013, 2'd3, 1'b0, 16'h0, "R6");
        pulse_frame();
        idle(6);
        chk(mig_valid == 1'b0, "R7", "no victim while all in flight", 64'(mig_valid), 64'(0));
        exp_mig(16'h0014, 2'd0, 1'b1, 16'h0010, "R7");
        ack(16'h0010);
        idle(12);
        chk(exp_m.size() == 0, "R10", "commands outstanding", 64'(exp_m.size()), 64'(0));
        chk(mig_valid == 1'b0, "R10", "dropped page never migrated", 64'(mig_valid), 64'(0));
        chk(exp_r.size() == 0, "R2", "routes outstanding", 64'(exp_r.size()), 64'(0));

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule